// File: doc/BRIEF.md
# Hashed Two-Port Bank Request Router

This block sits in front of four single-ported cache data banks and takes up to two access requests per clock, one on each request port. Each request names a byte address, a read or write direction, write data and a small token chosen by the requester. The router finds the bank from the line address. The plain line interleave bits are XOR-ed with the lowest bits of the tag, so that lines at a large power-of-two stride spread over all banks instead of piling into one. It then drives the enable of that bank.

When the two requests land in different banks, both are issued in the same clock. When they land in the same bank, one is issued and the other is parked in a small holding register on its own port. The parked request is issued in the following clock, and its port shows not-ready until then. A priority bit flips on every collision, so the two ports take turns and a parked request is never passed over. Every issued request returns a response one clock later on the port it came from. The response carries the requester's token and the bank's data word. The banks are plain register arrays with one word per row. Tag matching is left to the surrounding cache.

Top module: `bank_steer_router`

## Requirements
- R1: With the default parameters, the bank number is addr[7:6] XOR addr[13:12]. Bit b of bank_en is high in a clock in which a request is issued to bank b, in the same clock the request is presented.
- R2: Two accepted requests that map to different banks are both issued in the same clock, and both ports show resp_valid in the next clock.
- R3: Two accepted requests that map to the same bank: only one is issued in that clock. In the next clock the other port has req_ready low, and its held request is issued to the same bank.
- R4: The first same-bank collision after reset is won by port 0, and each later collision is won by the port that lost the previous one. A held request therefore waits exactly one clock.
- R5: resp_valid of a port is high for one clock, exactly one clock after that port's request is issued. resp_token then equals the token of that request.
- R6: A read response returns the word most recently written to the same bank and row. A write response returns the word being written.
- R7: The number of ports with resp_valid high equals the number of bank_en bits that were high in the previous clock.
- R8: While rst_n is low, and for two clocks after it rises, req_ready, resp_valid and bank_en are all zero, whatever the inputs. After that, both ports are ready.
- R9: While a port's req_ready is low, its req_valid, req_write, req_addr, req_wdata and req_token are ignored.
- R10: With the default parameters, the row inside a bank is addr[11:8]. Address bits [5:0] and bits above 13 affect neither bank nor row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 2 | Request present, one bit per port |
| req_ready | output | 2 | Port can take a request this clock |
| req_write | input | 2 | 1 = write, 0 = read, per port |
| req_addr | input | 2x32 | Byte address per port |
| req_wdata | input | 2x32 | Write word per port |
| req_token | input | 2x4 | Requester tag per port |
| bank_en | output | 4 | Bank issued this clock, one bit per bank |
| resp_valid | output | 2 | Response present, per port |
| resp_token | output | 2x4 | Token of the request being answered |
| resp_rdata | output | 2x32 | Read word, or written word for a write |

## Verification
The bench uses the default parameters: 64-byte lines, four banks, sixteen rows per bank and a four-bit token. With these values every bank, every row and the XOR hash can be reached with addresses below 0x4000. Pairs of addresses that differ only in interleave bits and tag bits land on the same bank and row. This makes same-bank collisions, write-after-write ordering inside a collision and the flip of priority directly observable. A bit set above the hashed range and a non-zero line offset show that these bits have no effect on the bank and row chosen.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int unsigned NPORT = 2;

  typedef enum logic {
    FAVOR_P0 = 1'b0,
    FAVOR_P1 = 1'b1
  } favor_e;
endpackage

// File: rtl/bsr_bank_hash.sv
module bsr_bank_hash #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row
);
  localparam int unsigned BANK_LSB = OFF_W;
  localparam int unsigned ROW_LSB  = OFF_W + BANK_W;
  localparam int unsigned TAG_LSB  = ROW_LSB + ROW_W;

  logic unused_addr_fold;

  // interleave bits folded with the lowest tag bits
  assign bank = addr[BANK_LSB +: BANK_W] ^ addr[TAG_LSB +: BANK_W];
  assign row  = addr[ROW_LSB +: ROW_W];
  assign unused_addr_fold = ^addr;
endmodule

// File: rtl/bsr_port_skid.sv
module bsr_port_skid #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TOK_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [TOK_W-1:0]  in_token,
  input  logic              grant,
  output logic              in_ready,
  output logic              cand_valid,
  output logic              cand_write,
  output logic [ADDR_W-1:0] cand_addr,
  output logic [DATA_W-1:0] cand_wdata,
  output logic [TOK_W-1:0]  cand_token
);
  logic              held_q, held_d, load;
  logic              held_write_q;
  logic [ADDR_W-1:0] held_addr_q;
  logic [DATA_W-1:0] held_wdata_q;
  logic [TOK_W-1:0]  held_token_q;

  assign in_ready = rst_n & ~held_q;

  always_comb begin
    cand_valid = held_q | (in_valid & in_ready);
    cand_write = held_q ? held_write_q : in_write;
    cand_addr  = held_q ? held_addr_q  : in_addr;
    cand_wdata = held_q ? held_wdata_q : in_wdata;
    cand_token = held_q ? held_token_q : in_token;
    load       = in_valid & in_ready & ~grant;
    held_d     = held_q;
    if (held_q && grant) begin
      held_d = 1'b0;
    end else if (load) begin
      held_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else begin
      held_q <= held_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      held_write_q <= in_write;
      held_addr_q  <= in_addr;
      held_wdata_q <= in_wdata;
      held_token_q <= in_token;
    end
  end
endmodule

// File: rtl/bsr_arbiter.sv
module bsr_arbiter
  import bsr_pkg::*;
#(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORT-1:0]  cand_valid,
  input  logic [BANK_W-1:0] bank_a,
  input  logic [BANK_W-1:0] bank_b,
  output logic [NPORT-1:0]  grant
);
  favor_e favor_q, favor_d;
  logic   clash;

  always_comb begin
    clash    = (&cand_valid) && (bank_a == bank_b);
    grant[0] = cand_valid[0] & (~clash | (favor_q == FAVOR_P0));
    grant[1] = cand_valid[1] & (~clash | (favor_q == FAVOR_P1));
    favor_d  = favor_q;
    if (clash) begin
      favor_d = (favor_q == FAVOR_P0) ? FAVOR_P1 : FAVOR_P0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      favor_q <= FAVOR_P0;
    end else begin
      favor_q <= favor_d;
    end
  end
endmodule

// File: rtl/bsr_bank.sv
module bsr_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROW_W  = 4
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] cells [ROWS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        cells[row] <= wdata;
      end
      rdata_q <= we ? wdata : cells[row];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/bank_steer_router.sv
module bank_steer_router
  import bsr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned TOK_W      = 4,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned BANK_ROWS  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              req_valid,
  output logic [NPORT-1:0]              req_ready,
  input  logic [NPORT-1:0]              req_write,
  input  logic [NPORT-1:0][ADDR_W-1:0]  req_addr,
  input  logic [NPORT-1:0][DATA_W-1:0]  req_wdata,
  input  logic [NPORT-1:0][TOK_W-1:0]   req_token,
  output logic [NUM_BANKS-1:0]          bank_en,
  output logic [NPORT-1:0]              resp_valid,
  output logic [NPORT-1:0][TOK_W-1:0]   resp_token,
  output logic [NPORT-1:0][DATA_W-1:0]  resp_rdata
);
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned BANK_W = $clog2(NUM_BANKS);
  localparam int unsigned ROW_W  = $clog2(BANK_ROWS);

  // reset: asserted at once, released through two flops
  logic rst_meta_n, rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_ok_n   <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_ok_n   <= rst_meta_n;
    end
  end

  logic [NPORT-1:0]              cand_valid, cand_write, grant;
  logic [NPORT-1:0][ADDR_W-1:0]  cand_addr;
  logic [NPORT-1:0][DATA_W-1:0]  cand_wdata;
  logic [NPORT-1:0][TOK_W-1:0]   cand_token;
  logic [NPORT-1:0][BANK_W-1:0]  cand_bank;
  logic [NPORT-1:0][ROW_W-1:0]   cand_row;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;

  logic [NPORT-1:0]              rsp_vld_q;
  logic [NPORT-1:0][TOK_W-1:0]   rsp_tok_q;
  logic [NPORT-1:0][BANK_W-1:0]  rsp_bank_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    bsr_port_skid #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOK_W(TOK_W)
    ) u_skid (
      .clk       (clk),
      .rst_n     (rst_ok_n),
      .in_valid  (req_valid[p]),
      .in_write  (req_write[p]),
      .in_addr   (req_addr[p]),
      .in_wdata  (req_wdata[p]),
      .in_token  (req_token[p]),
      .grant     (grant[p]),
      .in_ready  (req_ready[p]),
      .cand_valid(cand_valid[p]),
      .cand_write(cand_write[p]),
      .cand_addr (cand_addr[p]),
      .cand_wdata(cand_wdata[p]),
      .cand_token(cand_token[p])
    );

    bsr_bank_hash #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_hash (
      .addr(cand_addr[p]),
      .bank(cand_bank[p]),
      .row (cand_row[p])
    );

    always_ff @(posedge clk or negedge rst_ok_n) begin
      if (!rst_ok_n) begin
        rsp_vld_q[p] <= 1'b0;
      end else begin
        rsp_vld_q[p] <= grant[p];
      end
    end

    always_ff @(posedge clk) begin
      if (grant[p]) begin
        rsp_tok_q[p]  <= cand_token[p];
        rsp_bank_q[p] <= cand_bank[p];
      end
    end

    assign resp_valid[p] = rsp_vld_q[p];
    assign resp_token[p] = rsp_tok_q[p];
    assign resp_rdata[p] = bank_rdata[rsp_bank_q[p]];
  end

  bsr_arbiter #(.BANK_W(BANK_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_ok_n),
    .cand_valid(cand_valid),
    .bank_a    (cand_bank[0]),
    .bank_b    (cand_bank[1]),
    .grant     (grant)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              hit0, hit1, en, we;
    logic [ROW_W-1:0]  row;
    logic [DATA_W-1:0] wd;

    always_comb begin
      hit0 = grant[0] && (cand_bank[0] == BANK_W'(b));
      hit1 = grant[1] && (cand_bank[1] == BANK_W'(b));
      en   = hit0 | hit1;
      we   = hit1 ? cand_write[1] : cand_write[0];
      row  = hit1 ? cand_row[1]   : cand_row[0];
      wd   = hit1 ? cand_wdata[1] : cand_wdata[0];
    end

    assign bank_en[b] = en;

    bsr_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_bank (
      .clk  (clk),
      .en   (en),
      .we   (we),
      .row  (row),
      .wdata(wd),
      .rdata(bank_rdata[b])
    );
  end
endmodule

// File: rtl/bsr_checks.sv
module bsr_checks
  import bsr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned OFF_W     = 6,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned ROW_W     = 4,
  parameter int unsigned NUM_BANKS = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NPORT-1:0]             req_valid,
  input logic [NPORT-1:0]             req_ready,
  input logic [NPORT-1:0][ADDR_W-1:0] req_addr,
  input logic [NUM_BANKS-1:0]         bank_en,
  input logic [NPORT-1:0]             resp_valid
);
  localparam int unsigned TAG_LSB = OFF_W + BANK_W + ROW_W;

  logic [BANK_W-1:0] bank_a, bank_b;
  logic              both_in;
  logic              unused_chk_fold;

  assign bank_a  = req_addr[0][OFF_W +: BANK_W] ^ req_addr[0][TAG_LSB +: BANK_W];
  assign bank_b  = req_addr[1][OFF_W +: BANK_W] ^ req_addr[1][TAG_LSB +: BANK_W];
  assign both_in = (&req_valid) && (&req_ready);
  assign unused_chk_fold = ^req_addr;

  assert_split_banks_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (both_in && (bank_a != bank_b)) |=> (resp_valid == 2'b11));

  assert_clash_parks_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (both_in && (bank_a == bank_b)) |=> ($countones(req_ready) == 1));

  assert_park_one_clock_p0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready[0]) |=> req_ready[0]);

  assert_park_one_clock_p1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready[1]) |=> req_ready[1]);

  assert_resp_matches_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(resp_valid) == $countones($past(bank_en))));
endmodule

bind bank_steer_router bsr_checks #(
  .ADDR_W   (ADDR_W),
  .OFF_W    (OFF_W),
  .BANK_W   (BANK_W),
  .ROW_W    (ROW_W),
  .NUM_BANKS(NUM_BANKS)
) u_bsr_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .bank_en   (bank_en),
  .resp_valid(resp_valid)
);

// File: tb/bank_steer_router_bench.sv
`timescale 1ns/1ps
module bank_steer_router_bench;
  localparam int NV = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       req_valid, req_ready, req_write;
  logic [1:0][31:0] req_addr, req_wdata;
  logic [1:0][3:0]  req_token;
  logic [3:0]       bank_en;
  logic [1:0]       resp_valid;
  logic [1:0][3:0]  resp_token;
  logic [1:0][31:0] resp_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int exp_favor = 0;
  logic [31:0] mdl [4][16];

  always #4 clk = ~clk;

  bank_steer_router u_bank_steer_router (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_token(req_token),
    .bank_en(bank_en), .resp_valid(resp_valid),
    .resp_token(resp_token), .resp_rdata(resp_rdata)
  );

  typedef struct packed {
    logic v0; logic w0; logic [31:0] a0; logic [31:0] d0;
    logic v1; logic w1; logic [31:0] a1; logic [31:0] d1;
    logic [3:0] en;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 32'h0000_0040, 32'hA000_0001, 1'b1, 1'b1, 32'h0000_0080, 32'hA000_0002, 4'b0110},
    '{1'b1, 1'b1, 32'h0000_1000, 32'hA000_0003, 1'b1, 1'b1, 32'h0000_00C0, 32'hA000_0004, 4'b1010},
    '{1'b1, 1'b1, 32'h0000_0100, 32'hA000_0005, 1'b1, 1'b1, 32'h0000_1140, 32'hA000_0006, 4'b0001},
    '{1'b1, 1'b0, 32'h0000_0100, 32'h0,         1'b1, 1'b0, 32'h0000_0040, 32'h0,         4'b0011},
    '{1'b1, 1'b0, 32'h0000_0080, 32'h0,         1'b1, 1'b0, 32'h0000_2000, 32'h0,         4'b0100},
    '{1'b0, 1'b0, 32'h0000_0000, 32'h0,         1'b1, 1'b1, 32'h0000_3FC5, 32'hA000_0007, 4'b0001},
    '{1'b1, 1'b0, 32'h0000_3FC0, 32'h0,         1'b1, 1'b0, 32'h0000_0F00, 32'h0,         4'b0001},
    '{1'b1, 1'b1, 32'h0001_0200, 32'hA000_0008, 1'b1, 1'b0, 32'h0000_0100, 32'h0,         4'b0001}
  };

  function automatic logic [1:0] bk(input logic [31:0] a);
    return a[7:6] ^ a[13:12];
  endfunction

  function automatic logic [3:0] rw(input logic [31:0] a);
    return a[11:8];
  endfunction

  function automatic logic [31:0] macc(input logic w, input logic [31:0] a, input logic [31:0] d);
    if (w) begin
      mdl[bk(a)][rw(a)] = d;
      return d;
    end
    return mdl[bk(a)][rw(a)];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0; req_token = '0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    logic [1:0]       vin, w;
    logic [1:0][31:0] a, d, exp_d;
    logic [1:0][3:0]  tk;
    logic             clash;
    int               win, los;
    vin = {v.v1, v.v0}; w = {v.w1, v.w0};
    a[0] = v.a0; a[1] = v.a1; d[0] = v.d0; d[1] = v.d1;
    tk[0] = 4'(2 * idx); tk[1] = 4'(2 * idx + 1);
    exp_d = '0;
    clash = v.v0 && v.v1 && (bk(v.a0) == bk(v.a1));
    win = exp_favor; los = 1 - exp_favor;
    if (clash) begin
      exp_d[win] = macc(w[win], a[win], d[win]);
      exp_d[los] = macc(w[los], a[los], d[los]);
    end else begin
      for (int p = 0; p < 2; p++) if (vin[p]) exp_d[p] = macc(w[p], a[p], d[p]);
    end
    @(negedge clk);
    req_valid = vin; req_write = w; req_addr = a; req_wdata = d; req_token = tk;
    #1;
    chk(bank_en == v.en, "R1 R10 bank_en on issue", 64'(bank_en), 64'(v.en));
    @(negedge clk);
    idle_inputs();
    if (clash) begin
      chk(resp_valid == 2'(1 << win), "R3 R4 one winner", 64'(resp_valid), 64'(1 << win));
      chk(resp_token[win] == tk[win], "R5 winner token", 64'(resp_token[win]), 64'(tk[win]));
      chk(resp_rdata[win] == exp_d[win], "R6 R10 winner data", 64'(resp_rdata[win]), 64'(exp_d[win]));
      chk(req_ready[los] == 1'b0, "R3 loser not ready", 64'(req_ready[los]), 64'(0));
      #1;
      chk(bank_en == v.en, "R3 retry same bank", 64'(bank_en), 64'(v.en));
      @(negedge clk);
      chk(resp_valid == 2'(1 << los), "R4 R7 loser answered next", 64'(resp_valid), 64'(1 << los));
      chk(resp_token[los] == tk[los], "R5 loser token", 64'(resp_token[los]), 64'(tk[los]));
      chk(resp_rdata[los] == exp_d[los], "R6 R10 loser data", 64'(resp_rdata[los]), 64'(exp_d[los]));
      chk(req_ready == 2'b11, "R4 ready again", 64'(req_ready), 64'(3));
      exp_favor = 1 - exp_favor;
    end else begin
      chk(resp_valid == vin, "R2 R7 parallel responses", 64'(resp_valid), 64'(vin));
      for (int p = 0; p < 2; p++) begin
        if (vin[p]) begin
          chk(resp_token[p] == tk[p], "R5 token", 64'(resp_token[p]), 64'(tk[p]));
          chk(resp_rdata[p] == exp_d[p], "R6 R10 data", 64'(resp_rdata[p]), 64'(exp_d[p]));
        end
      end
    end
    @(negedge clk);
    chk(resp_valid == 2'b00, "R5 single-cycle response", 64'(resp_valid), 64'(0));
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    req_valid = 2'b11; req_addr[0] = 32'h40; req_addr[1] = 32'h80;
    #1;
    chk(req_ready == 2'b00, "R8 not ready in reset", 64'(req_ready), 64'(0));
    chk(bank_en == 4'b0000, "R8 no bank in reset", 64'(bank_en), 64'(0));
    chk(resp_valid == 2'b00, "R8 no response in reset", 64'(resp_valid), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(bank_en == 4'b0000, "R8 held after release", 64'(bank_en), 64'(0));
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    #1;
    chk(req_ready == 2'b11, "R8 ready after release", 64'(req_ready), 64'(3));
    chk(resp_valid == 2'b00, "R8 quiet after release", 64'(resp_valid), 64'(0));

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R9: inputs of a parked port are ignored; port 0 wins this clash
    @(negedge clk);
    req_valid = 2'b11; req_write = 2'b11;
    req_addr[0] = 32'h0000_0340; req_wdata[0] = 32'hB000_0001; req_token[0] = 4'h2;
    req_addr[1] = 32'h0000_1300; req_wdata[1] = 32'hB000_0002; req_token[1] = 4'h3;
    @(negedge clk);
    req_valid = 2'b10; req_write = 2'b10;
    req_addr[1] = 32'h0000_0080; req_wdata[1] = 32'h0000_DEAD; req_token[1] = 4'hF;
    #1;
    chk(req_ready[1] == 1'b0, "R9 parked port not ready", 64'(req_ready[1]), 64'(0));
    chk(bank_en == 4'b0010, "R9 only held bank issued", 64'(bank_en), 64'(2));
    @(negedge clk);
    idle_inputs();
    chk(resp_token[1] == 4'h3, "R9 held token kept", 64'(resp_token[1]), 64'(3));
    chk(resp_rdata[1] == 32'hB000_0002, "R9 held data kept", 64'(resp_rdata[1]), 64'(32'hB000_0002));
    mdl[1][3] = 32'hB000_0002;
    exp_favor = 1 - exp_favor;
    @(negedge clk);
    // read back the row the ignored write aimed at, and the parked write
    run_vec('{1'b1, 1'b0, 32'h0000_0080, 32'h0, 1'b1, 1'b0, 32'h0000_1300, 32'h0, 4'b0110}, 7);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule